// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM from power-on to a state where normal traffic may start. After reset it holds the clock enable low and drives no-operation commands for a programmable stable-clock interval. It then raises the clock enable and walks through a fixed command sequence: precharge of all banks, extended mode write enabling the DLL, a mode write that resets the DLL, a second precharge-all, two auto-refreshes, and a final mode write that sets the operating burst and latency. Between commands it waits the row precharge, refresh cycle and mode-write recovery times, each given in clock cycles.

The final mode write clears the DLL reset bit. A separate counter starts at the DLL-reset mode write and runs for the DLL lock interval. The ready flag rises only when both the final mode-write recovery and the lock interval are over. A synchronous restart input clears the ready flag and runs the whole sequence again, for example after the clock frequency has changed. Configuration inputs (CAS latency, burst length, burst type, driver strength) are sampled when the matching mode write is issued.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset or restart, `cke` is 0 and the command is NOP for STABLE_CYCLES clock cycles. `cke` then rises with NOP still driven, and it stays high until the next reset or restart. Commands are encoded on {`cs_n`,`ras_n`,`cas_n`,`we_n`} as NOP=0111, precharge=0010, auto-refresh=0001, mode write=0000.
- R2: The first command is precharge-all, with address bit 10 set, all other address bits 0 and bank 0. It comes one cycle after `cke` rises. The next command follows T_RP cycles after it.
- R3: The second command is the extended mode write: bank bits = 01, address bit 0 = 0 (DLL on), address bit 1 = `cfg_drive[0]`, address bit 6 = `cfg_drive[1]`, every other address bit 0. The next command follows T_MRD cycles after it.
- R4: The third command is a mode write with bank 00 and address bit 8 = 1 (DLL reset), with the mode fields as in R6. A precharge-all follows T_MRD cycles after it, and the DLL lock interval of DLL_LOCK cycles starts at this command.
- R5: Two auto-refreshes (address 0, bank 0) follow, the first T_RP cycles after the second precharge-all and the second T_RFC cycles after the first. The final mode write comes T_RFC cycles after the second refresh.
- R6: The final mode write has bank 00, address bits 8 and 7 = 0, bits 6..4 = `cfg_cas_lat` (011 = 3, 100 = 4), bit 3 = `cfg_interleave` (0 sequential, 1 interleave) and bits 2..0 = {0,`cfg_burst_log2`} (001 = 2, 010 = 4, 011 = 8).
- R7: `init_done` rises in the cycle after the later of two points: T_MRD cycles after the final mode write, or DLL_LOCK cycles after the DLL-reset mode write. It then stays high, with `cke` high and NOP driven, until reset or restart.
- R8: `restart` high at a clock edge has the same effect as reset. It clears `init_done`, drops `cke` and aborts any sequence in progress. The rerun uses the configuration present at that time.
- R9: Every command is a single cycle and is followed by at least one NOP cycle. Outside command cycles, the address and bank outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous request to rerun the sequence |
| cfg_cas_lat | input | 3 | CAS latency code for the mode word |
| cfg_burst_log2 | input | 2 | log2 of the burst length (1, 2 or 3) |
| cfg_interleave | input | 1 | Burst order: 0 sequential, 1 interleave |
| cfg_drive | input | 2 | Driver strength bits {A6,A1} for the extended mode word |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ROW_W | Address bus |
| ba | output | BANK_W | Bank select |
| init_done | output | 1 | Sequence complete, memory ready for use |

## Verification
The assertions require that T_RP, T_MRD and T_RFC are each at least two cycles, since they check that every command is followed by NOP. They also require that restart and reset are treated alike, so that properties spanning a restart edge are disabled. The bench drives `restart` only as a single-cycle pulse, placed away from command cycles, and changes the configuration only while `restart` is high. This keeps every mode word tied to one known setting. A second instance with a short lock interval covers the case where the final mode-write recovery, and not the DLL lock, sets the ready time.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MODE = 4'b0000,
    CMD_REFR = 4'b0001,
    CMD_PREC = 4'b0010,
    CMD_NOP  = 4'b0111
  } dram_cmd_t;

  typedef enum logic [3:0] {
    ST_STABLE     = 4'd0,
    ST_CKE_UP     = 4'd1,
    ST_PRE_A      = 4'd2,
    ST_EXT_MODE   = 4'd3,
    ST_MODE_DLL   = 4'd4,
    ST_PRE_B      = 4'd5,
    ST_REF_A      = 4'd6,
    ST_REF_B      = 4'd7,
    ST_MODE_FINAL = 4'd8,
    ST_LOCK_WAIT  = 4'd9,
    ST_READY      = 4'd10
  } init_step_t;

endpackage

// File: rtl/ddr_init_modeword.sv
module ddr_init_modeword
  import ddr_init_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input  init_step_t        step,
  input  logic [2:0]        cas_lat,
  input  logic [1:0]        burst_log2,
  input  logic              interleave,
  input  logic [1:0]        drive,
  output dram_cmd_t         cmd,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba
);

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    case (step)
      ST_PRE_A, ST_PRE_B: begin
        cmd      = CMD_PREC;
        addr[10] = 1'b1;
      end
      ST_EXT_MODE: begin
        cmd     = CMD_MODE;
        ba[0]   = 1'b1;
        addr[1] = drive[0];
        addr[6] = drive[1];
      end
      ST_MODE_DLL, ST_MODE_FINAL: begin
        cmd       = CMD_MODE;
        addr[2:0] = {1'b0, burst_log2};
        addr[3]   = interleave;
        addr[6:4] = cas_lat;
        addr[8]   = (step == ST_MODE_DLL);
      end
      ST_REF_A, ST_REF_B: cmd = CMD_REFR;
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
  parameter int LOCK_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic start,
  output logic lock_done
);

  localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);

  logic              armed;
  logic [LOCK_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      armed  <= 1'b0;
      remain <= '0;
    end else if (start) begin
      armed  <= 1'b1;
      remain <= LOCK_W'(LOCK_CYCLES);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign lock_done = armed && (remain == '0);

  // once lock is reached it persists until the next start or clear (R4)
  assert_lock_stays_R4: assert property (@(posedge clk) disable iff (rst || clear)
    (lock_done && !start) |=> lock_done);

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ROW_W         = 13,
  parameter int BANK_W        = 2,
  parameter int STABLE_CYCLES = 20000,
  parameter int T_RP          = 4,
  parameter int T_RFC         = 14,
  parameter int T_MRD         = 2,
  parameter int DLL_LOCK      = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [1:0]        cfg_burst_log2,
  input  logic              cfg_interleave,
  input  logic [1:0]        cfg_drive,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba,
  output logic              init_done
);

  localparam int GAP_A   = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int GAP_B   = (GAP_A > T_MRD) ? GAP_A : T_MRD;
  localparam int GAP_MAX = (GAP_B > STABLE_CYCLES) ? GAP_B : STABLE_CYCLES;
  localparam int CNT_W   = $clog2(GAP_MAX + 1);

  init_step_t        step, step_nx;
  logic [CNT_W-1:0]  gap_cnt;
  logic              advance, lock_start, lock_done;
  dram_cmd_t         mw_cmd, cmd_q;
  logic [ROW_W-1:0]  mw_addr;
  logic [BANK_W-1:0] mw_ba;

  function automatic logic [CNT_W-1:0] gap_of(input init_step_t s);
    case (s)
      ST_STABLE:                              gap_of = CNT_W'(STABLE_CYCLES - 1);
      ST_PRE_A, ST_PRE_B:                     gap_of = CNT_W'(T_RP - 1);
      ST_EXT_MODE, ST_MODE_DLL, ST_MODE_FINAL: gap_of = CNT_W'(T_MRD - 1);
      ST_REF_A, ST_REF_B:                     gap_of = CNT_W'(T_RFC - 1);
      default:                                gap_of = '0;
    endcase
  endfunction

  assign step_nx    = init_step_t'(step + 4'd1);
  assign advance    = (step != ST_LOCK_WAIT) && (step != ST_READY) && (gap_cnt == '0);
  assign lock_start = advance && (step_nx == ST_MODE_DLL);

  ddr_init_modeword #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_word (
    .step       (step_nx),
    .cas_lat    (cfg_cas_lat),
    .burst_log2 (cfg_burst_log2),
    .interleave (cfg_interleave),
    .drive      (cfg_drive),
    .cmd        (mw_cmd),
    .addr       (mw_addr),
    .ba         (mw_ba)
  );

  ddr_init_lock #(.LOCK_CYCLES(DLL_LOCK)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .clear     (restart),
    .start     (lock_start),
    .lock_done (lock_done)
  );

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      step      <= ST_STABLE;
      gap_cnt   <= gap_of(ST_STABLE);
      cke       <= 1'b0;
      cmd_q     <= CMD_NOP;
      addr      <= '0;
      ba        <= '0;
      init_done <= 1'b0;
    end else begin
      cmd_q <= CMD_NOP;
      addr  <= '0;
      ba    <= '0;
      if (step == ST_LOCK_WAIT) begin
        if (lock_done) begin
          step      <= ST_READY;
          init_done <= 1'b1;
        end
      end else if (advance) begin
        step    <= step_nx;
        gap_cnt <= gap_of(step_nx);
        cke     <= 1'b1;
        cmd_q   <= mw_cmd;
        addr    <= mw_addr;
        ba      <= mw_ba;
      end else if (step != ST_READY) begin
        gap_cnt <= gap_cnt - 1'b1;
      end
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

  // while the clock enable is low only NOP may be driven (R1)
  assert_cke_low_nop_R1: assert property (@(posedge clk) disable iff (rst || restart)
    !cke |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

  // the clock enable never drops inside a run (R1)
  assert_cke_stays_R1: assert property (@(posedge clk) disable iff (rst || restart)
    cke |=> cke);

  // each command lasts one cycle and is followed by NOP (R9)
  assert_cmd_single_R9: assert property (@(posedge clk) disable iff (rst || restart)
    ({cs_n, ras_n, cas_n, we_n} != CMD_NOP) |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

  // ready is never reported before the DLL lock interval is over (R7)
  assert_done_after_lock_R7: assert property (@(posedge clk) disable iff (rst || restart)
    init_done |-> lock_done);

  // ready persists, with the interface idle (R7)
  assert_done_holds_R7: assert property (@(posedge clk) disable iff (rst || restart)
    init_done |=> (init_done && cke && ({cs_n, ras_n, cas_n, we_n} == CMD_NOP)));

endmodule

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;

  localparam int S     = 50;
  localparam int RP    = 4;
  localparam int RFC   = 14;
  localparam int MRD   = 2;
  localparam int LOCK  = 200;
  localparam int LOCKF = 10;
  localparam logic [3:0] NOP = 4'b0111;

  typedef struct {
    int          cyc;
    logic [3:0]  cmd;
    logic [12:0] addr;
    logic [1:0]  ba;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restart = 1'b0;
  logic [2:0] cfg_cas_lat = 3'd3;
  logic [1:0] cfg_burst_log2 = 2'd2;
  logic cfg_interleave = 1'b0;
  logic [1:0] cfg_drive = 2'b00;

  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [12:0] addr;
  logic [1:0] ba;
  logic cke_f, cs_f, ras_f, cas_f, we_f, done_f;
  logic [12:0] addr_f;
  logic [1:0] ba_f;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int exp_done = 0;
  int exp_done_f = 0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  ddr_init_seq #(.STABLE_CYCLES(S), .T_RP(RP), .T_RFC(RFC), .T_MRD(MRD), .DLL_LOCK(LOCK)) dut_i (
    .clk(clk), .rst(rst), .restart(restart), .cfg_cas_lat(cfg_cas_lat),
    .cfg_burst_log2(cfg_burst_log2), .cfg_interleave(cfg_interleave), .cfg_drive(cfg_drive),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done));

  ddr_init_seq #(.STABLE_CYCLES(S), .T_RP(RP), .T_RFC(RFC), .T_MRD(MRD), .DLL_LOCK(LOCKF)) dut_fast_i (
    .clk(clk), .rst(rst), .restart(restart), .cfg_cas_lat(cfg_cas_lat),
    .cfg_burst_log2(cfg_burst_log2), .cfg_interleave(cfg_interleave), .cfg_drive(cfg_drive),
    .cke(cke_f), .cs_n(cs_f), .ras_n(ras_f), .cas_n(cas_f), .we_n(we_f),
    .addr(addr_f), .ba(ba_f), .init_done(done_f));

  always @(posedge clk) begin
    if (rst || restart) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, expv);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // driver: expected command stream and ready time for one run
  task automatic push_run(input logic [2:0] cl, input logic [1:0] bl, input logic il, input logic [1:0] drv);
    int m, f;
    logic [12:0] mode;
    m = S + 1 + RP + MRD;
    f = m + MRD + RP + RFC + RFC;
    mode = {6'd0, cl, il, 1'b0, bl};
    exp_q.push_back('{S + 1,      4'b0010, 13'h0400, 2'b00, "R2"});
    exp_q.push_back('{S + 1 + RP, 4'b0000, 13'(({12'd0, drv[1]} << 6) | ({12'd0, drv[0]} << 1)), 2'b01, "R3"});
    exp_q.push_back('{m,          4'b0000, mode | 13'h0100, 2'b00, "R4"});
    exp_q.push_back('{m + MRD,    4'b0010, 13'h0400, 2'b00, "R4"});
    exp_q.push_back('{m + MRD + RP, 4'b0001, 13'h0000, 2'b00, "R5"});
    exp_q.push_back('{m + MRD + RP + RFC, 4'b0001, 13'h0000, 2'b00, "R5"});
    exp_q.push_back('{f,          4'b0000, mode, 2'b00, "R6"});
    exp_done   = max2(f + MRD + 1, m + LOCK + 1);
    exp_done_f = max2(f + MRD + 1, m + LOCKF + 1);
  endtask

  // monitor: pops expected commands and checks timed points
  always @(negedge clk) begin
    if (!rst && !restart) begin
      if (cyc == 1) begin
        check(!cke && !init_done && {cs_n, ras_n, cas_n, we_n} == NOP, "R8", "idle after start",
              {cke, init_done, cs_n, ras_n, cas_n, we_n}, {2'b00, NOP});
        check(addr == 0 && ba == 0, "R9", "addr/bank zero", {ba, addr}, 0);
      end
      if (cyc == S - 1) check(cke == 1'b0, "R1", "cke low before stable end", cke, 0);
      if (cyc == S)
        check(cke && {cs_n, ras_n, cas_n, we_n} == NOP, "R1", "cke rise with NOP",
              {cke, cs_n, ras_n, cas_n, we_n}, {1'b1, NOP});
      if ({cs_n, ras_n, cas_n, we_n} != NOP) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected command", {cs_n, ras_n, cas_n, we_n}, NOP);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cyc == e.cyc, e.tag, "command cycle", cyc, e.cyc);
          check({cs_n, ras_n, cas_n, we_n} == e.cmd, e.tag, "command code", {cs_n, ras_n, cas_n, we_n}, e.cmd);
          check(addr == e.addr && ba == e.ba, e.tag, "bank/address", {ba, addr}, {e.ba, e.addr});
        end
      end
      if (cyc == exp_done - 1) check(!init_done, "R7", "done early", init_done, 0);
      if (cyc == exp_done)     check(init_done, "R7", "done at time", init_done, 1);
      if (cyc == exp_done + 4)
        check(init_done && cke && {cs_n, ras_n, cas_n, we_n} == NOP, "R7", "done held idle",
              {init_done, cke, cs_n, ras_n, cas_n, we_n}, {2'b11, NOP});
      if (cyc == exp_done_f - 1) check(!done_f, "R7", "fast done early", done_f, 0);
      if (cyc == exp_done_f)     check(done_f, "R7", "fast done at time", done_f, 1);
    end
  end

  task automatic do_restart(input logic [2:0] cl, input logic [1:0] bl, input logic il, input logic [1:0] drv);
    @(posedge clk); #2;
    restart = 1'b1;
    cfg_cas_lat = cl; cfg_burst_log2 = bl; cfg_interleave = il; cfg_drive = drv;
    exp_q.delete();
    push_run(cl, bl, il, drv);
    @(posedge clk); #2;
    restart = 1'b0;
  endtask

  task automatic finish_run();
    while (cyc < exp_done + 6) @(posedge clk);
    check(exp_q.size() == 0, "R5", "all commands seen", exp_q.size(), 0);
  endtask

  initial begin
    push_run(3'd3, 2'd2, 1'b0, 2'b00);
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    finish_run();
    // rerun with CL 4, burst 8, interleave, weak drive bit A6
    do_restart(3'd4, 2'd3, 1'b1, 2'b10);
    while (cyc < 70) @(posedge clk);
    // abort mid-sequence, rerun with CL 3, burst 2, sequential, drive bit A1
    do_restart(3'd3, 2'd1, 1'b0, 2'b01);
    finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule